// File: doc/BRIEF.md
# Serial PCM Word Transmitter with Optional Even Parity

This block turns one 7-bit quantized sample code into a ten-bit serial word on a single line. A word starts with a low start bit. The seven code bits follow, most significant first. Two trailing bits close the word. A per-word control chooses what the first trailing bit carries. It is either a plain high stop bit or an even-parity bit over the code. The second trailing bit is always a high stop bit. Turning parity on therefore leaves the word length unchanged.

Samples arrive on a parallel port with a valid/ready handshake. The block holds ready low while a word is pending or on the line. Line timing comes from a bit-rate enable pulse supplied by the surrounding system. The first enable pulse after a sample is accepted begins the start bit. Each later pulse advances the line by one bit.

For a receiver that shares the sender's timing, a one-cycle strobe marks the cycle in which the start bit goes onto the line. That receiver needs no start-bit detection to find word boundaries.

The external reset is asynchronous and active low. Its release is synchronised inside the block, so ready rises two clock edges after reset is released.

Top module: `pcm_word_tx`

## Requirements
- R1: While rst_n is low, ser_out is 1, s_ready is 0 and word_stb is 0. After rst_n goes high, s_ready becomes 1 following the second rising clock edge.
- R2: When no word is pending or being sent, ser_out stays at 1.
- R3: A sample is taken on a rising edge where s_valid and s_ready are both 1. From the next cycle, s_ready is 0 until the word ends, and s_valid and s_data have no effect during that time.
- R4: The word is sent as ten bits, each changing only on a bit_en edge. Position 0 is the start bit (0). Positions 1 to 7 are s_data[6] down to s_data[0]. Position 9 is a stop bit (1). The first bit_en edge after acceptance puts position 0 on the line.
- R5: With parity disabled for a word, position 8 is 1.
- R6: With parity enabled for a word, position 8 is the XOR of the seven code bits. Positions 1 to 8 then hold an even number of ones.
- R7: par_en is sampled on the accepting edge. Changes to par_en later in the word do not alter that word.
- R8: word_stb is 1 for exactly the one cycle after the edge that puts the start bit on the line, and is 0 otherwise.
- R9: The bit_en edge that follows position 9 returns ser_out to 1 and raises s_ready in the same cycle.
- R10: ser_out holds its value across clock edges on which bit_en is 0, however long the gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Sample code offered |
| s_data | input | 7 | Quantized sample code |
| s_ready | output | 1 | Block can take a sample |
| par_en | input | 1 | Use first trailing bit as even parity |
| bit_en | input | 1 | Bit-rate enable pulse |
| ser_out | output | 1 | Serial line, idles high |
| word_stb | output | 1 | One-cycle word-boundary strobe at start bit |

## Verification
The hardest conditions to reach from the ports are a change of par_en partway through a word and a held s_valid carrying changing data while the block is busy. Both must leave the word on the line untouched. The stimulus drives them deliberately while bit_en runs in every-cycle, fixed-gap and random-gap patterns. A sample is also offered in the very cycle that ready returns, so the end of one word and the acceptance of the next fall together. A behavioural queue model is compared with all three outputs on every cycle. The tag for the parity position follows the parity setting latched for that word.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PEND = 2'd1,
    PH_SEND = 2'd2
  } tx_phase_e;
endpackage

// File: rtl/pcm_tx_rstsync.sv
module pcm_tx_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/pcm_tx_frame.sv
module pcm_tx_frame #(
  parameter int DATA_W   = 7,
  parameter int TRAIL_W  = 2,
  parameter int WORD_LEN = 1 + DATA_W + TRAIL_W
) (
  input  logic [DATA_W-1:0]   code,
  input  logic                par_on,
  output logic [WORD_LEN-1:0] frame
);
  logic first_trail;

  // even parity: the code bits plus this bit carry an even count of ones
  always_comb begin
    first_trail = par_on ? ^code : 1'b1;
  end

  generate
    if (TRAIL_W > 1) begin : g_multi_trail
      assign frame = {1'b0, code, first_trail, {(TRAIL_W-1){1'b1}}};
    end else begin : g_single_trail
      assign frame = {1'b0, code, first_trail};
    end
  endgenerate
endmodule

// File: rtl/pcm_tx_ctrl.sv
module pcm_tx_ctrl
  import pcm_tx_pkg::*;
#(
  parameter int WORD_LEN = 10,
  localparam int CNT_W   = $clog2(WORD_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s_valid,
  input  logic bit_en,
  output logic ready,
  output logic load,
  output logic shift,
  output logic first,
  output logic finish
);
  tx_phase_e  phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    load    = 1'b0;
    shift   = 1'b0;
    first   = 1'b0;
    finish  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (s_valid) begin
          load    = 1'b1;
          phase_d = PH_PEND;
        end
      end
      PH_PEND: begin
        if (bit_en) begin
          shift   = 1'b1;
          first   = 1'b1;
          cnt_d   = CNT_W'(1);
          phase_d = PH_SEND;
        end
      end
      PH_SEND: begin
        if (bit_en) begin
          if (cnt_q == CNT_W'(WORD_LEN)) begin
            finish  = 1'b1;
            cnt_d   = '0;
            phase_d = PH_IDLE;
          end else begin
            shift = 1'b1;
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign ready = (phase_q == PH_IDLE) && rst_n;
endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift #(
  parameter int WORD_LEN = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [WORD_LEN-1:0] frame,
  input  logic                shift,
  input  logic                first,
  input  logic                finish,
  output logic                ser_out,
  output logic                word_stb
);
  logic [WORD_LEN-1:0] sreg_q, sreg_d;
  logic                line_q, line_d;
  logic                stb_q, stb_d;

  always_comb begin
    sreg_d = sreg_q;
    line_d = line_q;
    stb_d  = shift & first;
    if (load) begin
      sreg_d = frame;
    end else if (shift) begin
      line_d = sreg_q[WORD_LEN-1];
      sreg_d = {sreg_q[WORD_LEN-2:0], 1'b1};
    end else if (finish) begin
      line_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '1;
      line_q <= 1'b1;
      stb_q  <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      line_q <= line_d;
      stb_q  <= stb_d;
    end
  end

  assign ser_out  = line_q;
  assign word_stb = stb_q;
endmodule

// File: rtl/pcm_word_tx.sv
module pcm_word_tx #(
  parameter int DATA_W  = 7,
  parameter int TRAIL_W = 2,
  localparam int WORD_LEN = 1 + DATA_W + TRAIL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  input  logic              par_en,
  input  logic              bit_en,
  output logic              ser_out,
  output logic              word_stb
);
  logic rst_int_n;
  logic ld, sh, fst, fin;
  logic [WORD_LEN-1:0] frame;

  pcm_tx_rstsync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  pcm_tx_frame #(.DATA_W(DATA_W), .TRAIL_W(TRAIL_W), .WORD_LEN(WORD_LEN)) u_frame (
    .code   (s_data),
    .par_on (par_en),
    .frame  (frame)
  );

  pcm_tx_ctrl #(.WORD_LEN(WORD_LEN)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .s_valid (s_valid),
    .bit_en  (bit_en),
    .ready   (s_ready),
    .load    (ld),
    .shift   (sh),
    .first   (fst),
    .finish  (fin)
  );

  pcm_tx_shift #(.WORD_LEN(WORD_LEN)) u_shift (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (ld),
    .frame    (frame),
    .shift    (sh),
    .first    (fst),
    .finish   (fin),
    .ser_out  (ser_out),
    .word_stb (word_stb)
  );
endmodule

// File: rtl/pcm_word_tx_chk.sv
module pcm_word_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic s_valid,
  input logic s_ready,
  input logic bit_en,
  input logic ser_out,
  input logic word_stb
);
  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> ser_out);

  a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  a_r8_stb_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |-> !ser_out);

  a_r8_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |=> !word_stb);

  a_r10_hold_without_en: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(ser_out));
endmodule

bind pcm_word_tx pcm_word_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .s_valid  (s_valid),
  .s_ready  (s_ready),
  .bit_en   (bit_en),
  .ser_out  (ser_out),
  .word_stb (word_stb)
);

// File: tb/tb_pcm_word_tx.sv
`timescale 1ns/1ps
module tb_pcm_word_tx;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       s_valid;
  logic [6:0] s_data;
  logic       s_ready;
  logic       par_en;
  logic       bit_en;
  logic       ser_out;
  logic       word_stb;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit chk_on = 0;
  bit done   = 0;

  // bit_en pattern: 0 = every cycle, 1 = one in en_per, 2 = random
  int en_mode = 0;
  int en_per  = 3;
  int en_cnt  = 0;

  // reference model state
  bit q[$];
  int ph = 0;
  int rel = 0;
  int m_idx = 0;
  bit m_out = 1, m_stb = 0, m_ready = 0, m_par = 0, prev_en = 1, ready_rose = 0;
  string par_tag = "R5";

  pcm_word_tx dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .par_en(par_en), .bit_en(bit_en), .ser_out(ser_out), .word_stb(word_stb)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      q.delete(); ph = 0; rel = 0; m_out = 1; m_stb = 0; m_ready = 0; m_idx = 0;
      prev_en = 1; ready_rose = 0;
    end else begin
      bit was_ready;
      was_ready = m_ready;
      m_stb = 0;
      prev_en = bit_en;
      if (rel >= 2) begin
        case (ph)
          0: if (s_valid) begin
               q.delete();
               q.push_back(1'b0);
               for (int i = 6; i >= 0; i--) q.push_back(s_data[i]);
               m_par = par_en;
               q.push_back(par_en ? ^s_data : 1'b1);
               q.push_back(1'b1);
               ph = 1;
             end
          1: if (bit_en) begin
               m_out = q.pop_front(); m_idx = 0; m_stb = 1; ph = 2;
             end
          default: if (bit_en) begin
               if (q.size() == 0) begin m_out = 1; ph = 0; end
               else begin m_out = q.pop_front(); m_idx++; end
             end
        endcase
      end else begin
        rel++;
      end
      m_ready = (ph == 0) && (rel >= 2);
      ready_rose = m_ready && !was_ready;
    end
  end

  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      string t;
      if (ph == 0) t = "R2";
      else if (!prev_en) t = "R10";
      else if (m_idx == 8 && ph == 2) t = m_par ? "R6" : "R5";
      else t = "R4";
      if (ph == 2 && m_idx == 8 && prev_en && par_tag == "R7") t = "R7";
      check(t, ser_out, m_out, "ser_out");
      check(ready_rose ? "R9" : "R3", s_ready, m_ready, "s_ready");
      check("R8", word_stb, m_stb, "word_stb");
    end
  end

  always @(negedge clk) begin
    case (en_mode)
      0: bit_en = 1'b1;
      1: begin en_cnt = (en_cnt + 1) % en_per; bit_en = (en_cnt == 0); end
      default: bit_en = ($urandom_range(0, 3) == 0);
    endcase
  end

  task automatic send(input logic [6:0] d, input bit p, input bit hold_busy);
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    s_valid = 1'b1; s_data = d; par_en = p;
    @(negedge clk);
    if (hold_busy) begin
      // R3: offers while busy must be ignored
      for (int k = 0; k < 6; k++) begin
        s_data = ~d ^ 7'(k); par_en = ~p;
        @(negedge clk);
      end
    end
    s_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!s_ready) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; s_valid = 1'b0; s_data = '0; par_en = 1'b0;
    repeat (4) @(negedge clk);
    check("R1", ser_out, 1'b1, "ser_out in reset");
    check("R1", s_ready, 1'b0, "s_ready in reset");
    check("R1", word_stb, 1'b0, "word_stb in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", s_ready, 1'b0, "s_ready one edge after release");
    @(negedge clk);
    check("R1", s_ready, 1'b1, "s_ready two edges after release");
    chk_on = 1;

    // R4 R5: parity off, gapped enable
    en_mode = 1; en_per = 3; par_tag = "R5";
    send(7'h55, 1'b0, 1'b0); wait_idle();
    // R6: parity on, seven ones gives parity 1
    en_mode = 0; par_tag = "R6";
    send(7'h7F, 1'b1, 1'b0); wait_idle();
    send(7'h00, 1'b1, 1'b0); wait_idle();
    send(7'h01, 1'b1, 1'b0); wait_idle();
    // R3: s_valid held with changing data while busy
    en_mode = 1; en_per = 2; par_tag = "R3";
    send(7'h2C, 1'b0, 1'b1); wait_idle();
    // R7: par_en toggled during the word
    par_tag = "R7";
    fork
      send(7'h13, 1'b1, 1'b0);
      begin repeat (4) begin @(negedge clk); #1; par_en = ~par_en; end end
    join
    wait_idle();
    // R9: back-to-back words offered as soon as ready returns
    en_mode = 0; par_tag = "R9";
    @(negedge clk); s_valid = 1'b1; s_data = 7'h6A; par_en = 1'b1;
    for (int n = 0; n < 40; n++) @(negedge clk);
    s_valid = 1'b0; wait_idle();
    // R10: random gaps, mixed data
    en_mode = 2; par_tag = "R10";
    for (int w = 0; w < 12; w++) begin
      send(7'($urandom_range(0, 127)), bit'($urandom_range(0, 1)), bit'(w % 3 == 0));
      wait_idle();
    end
    en_mode = 1; en_per = 7;
    send(7'h3B, 1'b1, 1'b0); wait_idle();
    repeat (5) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog run did not finish actual=%0d expected<150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule